// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running nanosecond time value for precision time protocol work. On every enabled reference clock cycle the count advances by a programmable step. Frequency trim works by substitution: when a correction period N is programmed, one enabled cycle in every N adds a separate correction step instead of the normal step. A step below the normal one slows the clock; a step above it speeds the clock up.

The count can either roll over naturally at the full register width or, in period mode, fold back to the excess above a programmable event period. A period of 2^31 turns the block into a 31-bit nanosecond counter. A single-cycle wrap pulse marks each fold, so that compare channels can follow the roll-over. Software reaches the block through a flat register port. Through it, software can start and stop counting, restart the count at zero, load any count directly, and take a snapshot of the running count to read back later. The live count is also driven out on its own port for compare logic.

Top module: `adj_ns_counter`

## Requirements
- R1: After reset the live count, wrap pulse, control word, step fields and correction period are all zero, and the event period reads 0x8000_0000.
- R2: While control bit 0 is set, each clock cycle adds the normal step, which is held in bits 6:0 of the increment register (address 4).
- R3: When the correction period (address 3) is N and N is not zero, every Nth enabled cycle adds the correction step (increment register bits 14:8) in place of the normal step. N=1 corrects every cycle, N=0 never corrects, and writing address 3 restarts the cycle count used for the correction.
- R4: With control bit 4 set, a sum that reaches the event period (address 2) becomes the sum minus the period, and wrapPulse is high for exactly the following cycle. With bit 4 clear, the count rolls over modulo 2^32 and wrapPulse stays low.
- R5: Writing the control word with bit 9 set clears the count to zero at that edge and restarts the correction cycle count. Bit 9 always reads back as 0.
- R6: Writing the control word with bit 11 set makes bit 11 read 1 for one cycle. At the next edge the live count is copied into the snapshot, and bit 11 clears. Reads of address 1 return the snapshot.
- R7: A write to address 1 loads the written value into the live count at that edge. The load takes priority over counting.
- R8: While control bit 0 is clear, the count holds its value.
- R9: Control bits 0, 4, 5 and 11 are stored and read back at address 0. Unused addresses read zero, and the read data is combinational on regAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 control, 1 count, 2 period, 3 correction period, 4 increment) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| timeNow | output | 32 | Live nanosecond count |
| wrapPulse | output | 1 | One-cycle pulse after a period fold |

## Verification
The step logic is driven with several correction periods: zero, one, and small values above one. Each is compared cycle by cycle against a bench model. This separates "never corrects" from "always corrects" from a phase that is off by one. The period fold is tried with small random periods, which fold often, and with the 2^31 period. A load just below the period checks both the fold arithmetic and the timing of the pulse. The mode without folding is checked at the 2^32 boundary to show that it rolls over with no pulse. Restart, load and capture are mixed in at random times to check their priorities against counting, and to check that the snapshot is the count from the cycle after the capture request.

// File: rtl/adj_ns_pkg.sv
package adj_ns_pkg;

  // register addresses
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_TIME   = 3'd1;
  localparam logic [2:0] ADDR_PERIOD = 3'd2;
  localparam logic [2:0] ADDR_CORR   = 3'd3;
  localparam logic [2:0] ADDR_INC    = 3'd4;

  // control word bit positions
  localparam int BIT_EN      = 0;
  localparam int BIT_PRST    = 4;
  localparam int BIT_PRST_HI = 5;
  localparam int BIT_RESTART = 9;
  localparam int BIT_CAPTURE = 11;

  // lsb of the correction step inside the increment word
  localparam int CORR_LSB = 8;

  typedef struct packed {
    logic restart;
    logic load;
    logic advance;
    logic wrapEn;
    logic capture;
  } cnt_stb_t;

endpackage

// File: rtl/adj_ns_ctrl.sv
module adj_ns_ctrl
  import adj_ns_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output cnt_stb_t         stb,
  output logic [INC_W-1:0] stepVal,
  output logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] ctrlWord,
  output logic [CNT_W-1:0] corrPerWord,
  output logic [CNT_W-1:0] incWord
);

  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_PERIOD = CNT_ONE << (CNT_W - 1);
  localparam logic [CNT_W-1:0] CTRL_MASK  = (CNT_ONE << BIT_EN) | (CNT_ONE << BIT_PRST) |
                                            (CNT_ONE << BIT_PRST_HI) | (CNT_ONE << BIT_CAPTURE);

  logic [CNT_W-1:0] ctrlQ;
  logic [CNT_W-1:0] periodQ;
  logic [CNT_W-1:0] corrPerQ;
  logic [CNT_W-1:0] corrCntQ;
  logic [INC_W-1:0] incQ;
  logic [INC_W-1:0] corrIncQ;

  logic wrCtrl, wrTime, wrPeriod, wrCorr, wrInc;
  logic restartNow, corrHit;

  assign wrCtrl   = regWe && (regAddr == ADDR_CTRL);
  assign wrTime   = regWe && (regAddr == ADDR_TIME);
  assign wrPeriod = regWe && (regAddr == ADDR_PERIOD);
  assign wrCorr   = regWe && (regAddr == ADDR_CORR);
  assign wrInc    = regWe && (regAddr == ADDR_INC);

  assign restartNow = wrCtrl && regWdata[BIT_RESTART];

  // this enabled cycle is the Nth of its correction window
  assign corrHit = ctrlQ[BIT_EN] && (corrPerQ != '0) && ((corrCntQ + CNT_ONE) == corrPerQ);
  assign stepVal = corrHit ? corrIncQ : incQ;

  always_comb begin
    stb.restart = restartNow;
    stb.load    = wrTime;
    stb.advance = ctrlQ[BIT_EN];
    stb.wrapEn  = ctrlQ[BIT_PRST];
    stb.capture = ctrlQ[BIT_CAPTURE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      periodQ  <= RST_PERIOD;
      corrPerQ <= '0;
      corrCntQ <= '0;
      incQ     <= '0;
      corrIncQ <= '0;
    end else begin
      if (wrCtrl) begin
        ctrlQ <= regWdata & CTRL_MASK;
      end else if (ctrlQ[BIT_CAPTURE]) begin
        ctrlQ[BIT_CAPTURE] <= 1'b0;
      end

      if (wrPeriod) periodQ <= regWdata;
      if (wrCorr)   corrPerQ <= regWdata;
      if (wrInc) begin
        incQ     <= regWdata[INC_W-1:0];
        corrIncQ <= regWdata[CORR_LSB +: INC_W];
      end

      if (wrCorr || restartNow) begin
        corrCntQ <= '0;
      end else if (ctrlQ[BIT_EN]) begin
        corrCntQ <= corrHit ? '0 : corrCntQ + CNT_ONE;
      end
    end
  end

  always_comb begin
    incWord = '0;
    incWord[INC_W-1:0] = incQ;
    incWord[CORR_LSB +: INC_W] = corrIncQ;
  end

  assign periodVal   = periodQ;
  assign ctrlWord    = ctrlQ;
  assign corrPerWord = corrPerQ;

endmodule

// File: rtl/adj_ns_datapath.sv
module adj_ns_datapath
  import adj_ns_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_stb_t         stb,
  input  logic [INC_W-1:0] stepVal,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] timeQ,
  output logic [CNT_W-1:0] snapQ,
  output logic             wrapQ
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] folded;
  logic             wrapHit;
  logic [CNT_W-1:0] nextTime;

  assign sum      = {1'b0, timeQ} + {{(SUM_W - INC_W){1'b0}}, stepVal};
  assign wrapHit  = stb.wrapEn && (sum >= {1'b0, periodVal});
  assign folded   = sum - {1'b0, periodVal};
  assign nextTime = wrapHit ? folded[CNT_W-1:0] : sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeQ <= '0;
      snapQ <= '0;
      wrapQ <= 1'b0;
    end else begin
      if (stb.restart) begin
        timeQ <= '0;
      end else if (stb.load) begin
        timeQ <= loadVal;
      end else if (stb.advance) begin
        timeQ <= nextTime;
      end

      wrapQ <= stb.advance && wrapHit && !stb.restart && !stb.load;

      if (stb.capture) snapQ <= timeQ;
    end
  end

endmodule

// File: rtl/adj_ns_counter.sv
module adj_ns_counter
  import adj_ns_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  output logic [CNT_W-1:0] timeNow,
  output logic             wrapPulse
);

  cnt_stb_t         stb;
  logic [INC_W-1:0] stepVal;
  logic [CNT_W-1:0] periodVal;
  logic [CNT_W-1:0] ctrlWord;
  logic [CNT_W-1:0] corrPerWord;
  logic [CNT_W-1:0] incWord;
  logic [CNT_W-1:0] snapQ;

  adj_ns_ctrl #(.CNT_W(CNT_W), .INC_W(INC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .stb(stb), .stepVal(stepVal), .periodVal(periodVal), .ctrlWord(ctrlWord),
    .corrPerWord(corrPerWord), .incWord(incWord)
  );

  adj_ns_datapath #(.CNT_W(CNT_W), .INC_W(INC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .stepVal(stepVal), .periodVal(periodVal),
    .loadVal(regWdata), .timeQ(timeNow), .snapQ(snapQ), .wrapQ(wrapPulse)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL:   regRdata = ctrlWord;
      ADDR_TIME:   regRdata = snapQ;
      ADDR_PERIOD: regRdata = periodVal;
      ADDR_CORR:   regRdata = corrPerWord;
      ADDR_INC:    regRdata = incWord;
      default:     regRdata = '0;
    endcase
  end

endmodule

// File: rtl/adj_ns_counter_chk.sv
module adj_ns_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [2:0]       regAddr,
  input logic [CNT_W-1:0] regWdata,
  input logic [CNT_W-1:0] timeNow,
  input logic             wrapPulse,
  input logic [CNT_W-1:0] ctrlWord
);

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd0 && regWdata[9]) |=> (timeNow == '0));

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd1) |=> (timeNow == $past(regWdata)));

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWord[0] && !regWe) |=> $stable(timeNow));

  // R4
  wrap_needs_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> $past(ctrlWord[0] && ctrlWord[4]));

  // R6
  capture_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[11] && !(regWe && regAddr == 3'd0)) |=> !ctrlWord[11]);

endmodule

bind adj_ns_counter adj_ns_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .timeNow(timeNow), .wrapPulse(wrapPulse), .ctrlWord(ctrlWord)
);

// File: tb/adj_ns_counter_tb.sv
`timescale 1ns/1ps
module adj_ns_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] timeNow;
  logic        wrapPulse;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  adj_ns_counter u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .timeNow(timeNow), .wrapPulse(wrapPulse)
  );

  // bench model of the register-level behaviour
  logic [31:0] mCtrl, mPeriod, mCorrPer, mCorrCnt, mCount, mSnap;
  logic [6:0]  mInc, mCorrInc;
  logic        mWrap;

  always @(posedge clk or negedge rstN) begin : mdl
    logic wC, wT, wP, wN, wI, rst, hit, fold;
    logic [32:0] s;
    logic [31:0] nCount;
    if (!rstN) begin
      mCtrl = 0; mPeriod = 32'h8000_0000; mCorrPer = 0; mCorrCnt = 0;
      mCount = 0; mSnap = 0; mInc = 0; mCorrInc = 0; mWrap = 0;
    end else begin
      wC = regWe && regAddr == 3'd0;
      wT = regWe && regAddr == 3'd1;
      wP = regWe && regAddr == 3'd2;
      wN = regWe && regAddr == 3'd3;
      wI = regWe && regAddr == 3'd4;
      rst = wC && regWdata[9];
      hit = mCtrl[0] && mCorrPer != 0 && (mCorrCnt + 1) == mCorrPer;
      s = {1'b0, mCount} + {26'd0, (hit ? mCorrInc : mInc)};
      fold = mCtrl[4] && s >= {1'b0, mPeriod};
      nCount = mCount;
      if (rst) nCount = 0;
      else if (wT) nCount = regWdata;
      else if (mCtrl[0]) nCount = fold ? 32'(s - {1'b0, mPeriod}) : s[31:0];
      mWrap = mCtrl[0] && fold && !rst && !wT;
      if (mCtrl[11]) mSnap = mCount;
      if (wN || rst) mCorrCnt = 0;
      else if (mCtrl[0]) mCorrCnt = hit ? 0 : mCorrCnt + 1;
      if (wC) mCtrl = regWdata & 32'h0000_0831;
      else if (mCtrl[11]) mCtrl[11] = 1'b0;
      if (wP) mPeriod = regWdata;
      if (wN) mCorrPer = regWdata;
      if (wI) begin mInc = regWdata[6:0]; mCorrInc = regWdata[14:8]; end
      mCount = nCount;
    end
  end

  function automatic logic [31:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mCtrl;
      3'd1: return mSnap;
      3'd2: return mPeriod;
      3'd3: return mCorrPer;
      3'd4: return {17'd0, mCorrInc, 1'b0, mInc};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison of the live outputs against the model (R2 R3 R4)
  always @(negedge clk) begin
    if (rstN && live) begin
      chk(timeNow, mCount, "R2/R3 live count");
      chk({31'd0, wrapPulse}, {31'd0, mWrap}, "R4 wrap pulse");
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input string tag);
    regAddr = a;
    #0.5;
    chk(regRdata, mRead(a), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: got cycle %0d exp finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] t0, t1;
    void'($urandom(32'd20240611));
    #9 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(timeNow, 32'd0, "R1 count");
    chk({31'd0, wrapPulse}, 32'd0, "R1 wrap");
    regAddr = 3'd2; #0.5; chk(regRdata, 32'h8000_0000, "R1 period");
    regAddr = 3'd0; #0.5; chk(regRdata, 32'd0, "R1 ctrl");
    regAddr = 3'd4; #0.5; chk(regRdata, 32'd0, "R1 inc");
    regAddr = 3'd3; #0.5; chk(regRdata, 32'd0, "R1 corr period");
    live = 1'b1;

    // R9 register readback
    wr(3'd4, 32'h0000_0905);
    rdChk(3'd4, "R9 inc word");
    regAddr = 3'd4; #0.5; chk(regRdata, 32'h0000_0905, "R9 inc fields");
    wr(3'd0, 32'hFFFF_F5FF);
    regAddr = 3'd0; #0.5; chk(regRdata, 32'h0000_0031, "R9 ctrl mask");
    regAddr = 3'd7; #0.5; chk(regRdata, 32'd0, "R9 unused addr");

    // R2 normal step, no correction, no fold
    wr(3'd0, 32'h1);
    wr(3'd1, 32'd100);
    @(negedge clk); t0 = timeNow;
    @(negedge clk); t1 = timeNow;
    chk(t1 - t0, 32'd5, "R2 step of 5");

    // R3 correction every cycle
    wr(3'd3, 32'd1);
    @(negedge clk); t0 = timeNow;
    @(negedge clk); t1 = timeNow;
    chk(t1 - t0, 32'd9, "R3 period 1 uses correction");
    // R3 correction every third cycle
    wr(3'd3, 32'd3);
    idle(30);
    // R3 zero period disables correction
    wr(3'd3, 32'd0);
    @(negedge clk); t0 = timeNow;
    @(negedge clk); t1 = timeNow;
    chk(t1 - t0, 32'd5, "R3 period 0 no correction");

    // R8 hold while disabled
    wr(3'd0, 32'h0);
    t0 = timeNow;
    idle(5);
    chk(timeNow, t0, "R8 hold when disabled");

    // R4 31-bit fold at period 2^31
    wr(3'd4, 32'd8);
    wr(3'd2, 32'h8000_0000);
    wr(3'd0, 32'h31);
    wr(3'd1, 32'h7FFF_FFFC);
    chk(timeNow, 32'h8000_0004 - 32'd8, "R7 load value");
    @(negedge clk);
    chk(timeNow, 32'd4, "R4 fold to excess");
    chk({31'd0, wrapPulse}, 32'd1, "R4 pulse high");
    @(negedge clk);
    chk({31'd0, wrapPulse}, 32'd0, "R4 pulse one cycle");

    // R4 no fold mode: modulo 2^32 without pulse
    wr(3'd0, 32'h1);
    wr(3'd1, 32'hFFFF_FFFC);
    @(negedge clk);
    chk(timeNow, 32'd4, "R4 natural rollover");
    chk({31'd0, wrapPulse}, 32'd0, "R4 no pulse without mode");

    // R5 restart
    idle(3);
    wr(3'd0, 32'h201);
    chk(timeNow, 32'd0, "R5 restart clears");
    regAddr = 3'd0; #0.5; chk(regRdata, 32'h1, "R5 restart bit reads 0");

    // R6 capture
    idle(4);
    wr(3'd0, 32'h801);
    t0 = timeNow;
    regAddr = 3'd0; #0.5; chk(regRdata, 32'h801, "R6 capture bit set");
    @(negedge clk);
    regAddr = 3'd1; #0.5; chk(regRdata, t0, "R6 snapshot value");
    regAddr = 3'd0; #0.5; chk(regRdata, 32'h1, "R6 capture bit cleared");

    // random segments
    for (int seg = 0; seg < 14; seg++) begin
      logic [31:0] per, ctl;
      logic pm;
      pm = ($urandom % 2) == 1;
      per = (($urandom % 4) == 0) ? 32'h8000_0000 : 32'(40 + $urandom % 3000);
      ctl = pm ? 32'h31 : 32'h1;
      wr(3'd4, $urandom & 32'h7F7F);
      wr(3'd3, $urandom % 7);
      wr(3'd2, per);
      wr(3'd0, ctl);
      wr(3'd1, pm ? ($urandom % per) : $urandom);
      for (int k = 0; k < 250; k++) begin
        int r;
        r = $urandom % 40;
        if (r == 0) wr(3'd0, ctl | 32'h800);
        else if (r == 1) wr(3'd0, ctl | 32'h200);
        else if (r == 2) wr(3'd1, pm ? ($urandom % per) : $urandom);
        else if (r == 3) wr(3'd0, ctl & ~32'h1);
        else if (r == 4) wr(3'd0, ctl);
        else @(negedge clk);
        rdChk(3'($urandom % 6), "R6/R9 random read");
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule